// File: doc/BRIEF.md
# Segment Descriptor Loader

This block loads a 16-bit selector into one segment register and keeps that register's cached copy: selector, 32-bit base, 32-bit limit and attribute bits. A load request names the selector, the class of register being loaded (data, code or stack), the current privilege level, the protection-enable bit and the virtual-8086 flag. Two tables may hold descriptors: a global one and a local one. The base and byte limit of each table arrive as inputs.

With protection off, or in virtual-8086 mode, only the selector and the base change. The base is the selector times sixteen. In protected mode the block first checks the selector against the table limit. It then reads the 8-byte descriptor through a single-beat memory read port and applies the type and privilege checks for the register class, in a fixed order. The result is either an update of the cached register or a fault code with an error code. A successful code load also reports a new privilege level equal to the selector's requested level. Gate descriptors are not handled.

Top module: `seg_loader`

## Requirements
- R1: After reset the cached selector, base and attributes are zero and the cached limit is 0x0000FFFF. `busy`, `done`, `mem_req` and `cpl_wr` are low and `flt_code` is 0.
- R2: When `pe` is 0 or `v86` is 1, a request makes no memory read. `done` rises one cycle later with `flt_code` 0. The cached selector becomes the request selector and the cached base becomes the selector shifted left by 4. The cached limit and attributes keep their values.
- R3: In protected mode, selector bit 2 picks the local table (1) or the global table (0). The read address is that table's base plus the selector with its low three bits cleared. If that offset is greater than the table limit, the load ends one cycle later with GP and the selector as error code, and no read is made.
- R4: Stack loads fault in this priority: index zero gives GP with error 0 and no read; system descriptor (bit 44 clear) gives GP; executable, or writable bit clear, gives GP; RPL (selector bits 1:0) unequal to CPL or to DPL gives GP; not present gives SS.
- R5: Code loads fault in this priority: index zero gives GP with error 0 and no read; system descriptor gives GP; not present gives NP; not executable gives GP. Then, if conforming, DPL greater than CPL gives GP. If not conforming, RPL greater than CPL, or CPL unequal to DPL, gives GP.
- R6: Data loads, including class 3 and selector index zero, read the descriptor and fault in this priority: system descriptor gives GP; RPL greater than DPL, or CPL greater than DPL, gives GP; not present gives NP.
- R7: The descriptor is read as follows. Limit: bits 15:0, with bits 51:48 as the high part. Base: bits 31:16 low, 39:32 middle, 63:56 high. Access flags: bit 40 accessed, 41 writable/readable, 42 conforming, 43 executable, 44 code-or-data, 46:45 DPL, 47 present. Bit 54 is the default size and bit 55 the granularity. On success the cache takes the selector, the assembled base, and the 20-bit limit, shifted left by 12 when granularity is set. `cur_attr` becomes {bit 54, bits 47:40}.
- R8: A successful protected code load pulses `cpl_wr` together with `done`, with `cpl_new` equal to the selector's RPL. No other load pulses `cpl_wr`.
- R9: `flt_code` encodes 0 none, 1 GP, 2 NP, 3 SS. Any fault leaves the cached selector, base, limit and attributes unchanged. Apart from the two null-index cases, the error code of a fault is the selector.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `done` pulses for one cycle, in the cycle after the acknowledge. While `busy` is high, new requests are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request, taken when not busy |
| req_sel | input | 16 | Selector to load |
| req_class | input | 2 | 0 data, 1 code, 2 stack, 3 treated as data |
| pe | input | 1 | Protection enable |
| v86 | input | 1 | Virtual-8086 mode flag |
| cpl_in | input | 2 | Current privilege level |
| gdt_base | input | 32 | Global table base address |
| gdt_limit | input | 16 | Global table byte limit |
| ldt_base | input | 32 | Local table base address |
| ldt_limit | input | 16 | Local table byte limit |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 64 | Descriptor contents |
| busy | output | 1 | Waiting for the descriptor |
| done | output | 1 | One-cycle completion pulse |
| flt_code | output | 2 | Fault code of the last load |
| flt_err | output | 16 | Error code of the last fault |
| cpl_wr | output | 1 | Privilege-level update pulse |
| cpl_new | output | 2 | New privilege level |
| cur_sel | output | 16 | Cached selector |
| cur_base | output | 32 | Cached base |
| cur_limit | output | 32 | Cached limit |
| cur_attr | output | 9 | Cached attributes {size, access byte} |

## Verification
The bench builds the block with the package defaults: 16-bit selectors, 32-bit addresses and 64-bit descriptors. At these widths the exact descriptor bit layout applies, and a 20-bit limit shifted by 12 exactly fills the cached limit. Both table sizes are set small enough that an offset landing just inside or just past each limit can be reached. Every level of each fault priority chain is reached, along with pairs of defects that show which check wins. Stalled acknowledges show that requests arriving while busy are ignored.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int SEL_W   = 16;
    localparam int ADDR_W  = 32;
    localparam int DESC_W  = 64;
    localparam int LIM_W   = 20;
    localparam int ACC_W   = 8;
    localparam int ATTR_W  = ACC_W + 1;
    localparam int PL_W    = 2;
    localparam int GRAN_SH = 12;
    localparam int REAL_SH = 4;
    localparam int IDX_LSB = 3;
    localparam logic [ADDR_W-1:0] RESET_LIMIT = ADDR_W'(32'h0000_FFFF);

    typedef enum logic [1:0] {
        SC_DATA  = 2'd0,
        SC_CODE  = 2'd1,
        SC_STACK = 2'd2,
        SC_RSVD  = 2'd3
    } seg_class_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_NP   = 2'd2,
        FLT_SS   = 2'd3
    } fault_e;

    typedef struct packed {
        logic [7:0]  base_hi;
        logic        gran;
        logic        big;
        logic [1:0]  spare;
        logic [3:0]  lim_hi;
        logic        present;
        logic [1:0]  dpl;
        logic        code_data;
        logic        exec;
        logic        conf;
        logic        rw;
        logic        acc;
        logic [7:0]  base_mid;
        logic [15:0] base_lo;
        logic [15:0] lim_lo;
    } desc_t;

    typedef struct packed {
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] limit;
        logic [ATTR_W-1:0] attr;
    } cache_t;

    function automatic logic [PL_W-1:0] eff_priv(input logic v86_on, input logic [PL_W-1:0] cpl);
        return v86_on ? PL_W'(3) : cpl;
    endfunction

    function automatic logic [ADDR_W-1:0] desc_base(input desc_t d);
        return {d.base_hi, d.base_mid, d.base_lo};
    endfunction

    function automatic logic [ADDR_W-1:0] desc_limit(input desc_t d);
        logic [LIM_W-1:0] raw;
        raw = {d.lim_hi, d.lim_lo};
        return d.gran ? (ADDR_W'(raw) << GRAN_SH) : ADDR_W'(raw);
    endfunction

    function automatic logic [ATTR_W-1:0] desc_attr(input desc_t d);
        return {d.big, d.present, d.dpl, d.code_data, d.exec, d.conf, d.rw, d.acc};
    endfunction
endpackage

// File: rtl/seg_precheck.sv
module seg_precheck
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0]  sel,
    input  seg_class_e        cls,
    input  logic [ADDR_W-1:0] gdt_base,
    input  logic [SEL_W-1:0]  gdt_limit,
    input  logic [ADDR_W-1:0] ldt_base,
    input  logic [SEL_W-1:0]  ldt_limit,
    output logic [ADDR_W-1:0] rd_addr,
    output fault_e            pre_flt,
    output logic [SEL_W-1:0]  pre_err
);
    logic [SEL_W-1:0]  byte_off;
    logic [ADDR_W-1:0] tbl_base;
    logic [SEL_W-1:0]  tbl_lim;
    logic              null_idx;
    logic              needs_nonnull;

    always_comb begin
        byte_off      = {sel[SEL_W-1:IDX_LSB], IDX_LSB'(0)};
        tbl_base      = sel[2] ? ldt_base  : gdt_base;
        tbl_lim       = sel[2] ? ldt_limit : gdt_limit;
        rd_addr       = tbl_base + ADDR_W'(byte_off);
        null_idx      = (sel[SEL_W-1:IDX_LSB] == '0);
        needs_nonnull = (cls == SC_CODE) || (cls == SC_STACK);
        pre_flt       = FLT_NONE;
        pre_err       = '0;
        if (byte_off > tbl_lim) begin
            pre_flt = FLT_GP;
            pre_err = sel;
        end else if (null_idx && needs_nonnull) begin
            pre_flt = FLT_GP;
            pre_err = '0;
        end
    end
endmodule

// File: rtl/seg_desc_check.sv
module seg_desc_check
    import seg_pkg::*;
(
    input  seg_class_e        cls,
    input  logic [SEL_W-1:0]  sel,
    input  logic [PL_W-1:0]   cpl,
    input  logic [DESC_W-1:0] desc_raw,
    output fault_e            flt,
    output logic [SEL_W-1:0]  err
);
    desc_t            d;
    logic [PL_W-1:0]  rpl;

    always_comb begin
        d   = desc_t'(desc_raw);
        rpl = sel[PL_W-1:0];
        flt = FLT_NONE;
        unique case (cls)
            SC_STACK: begin
                if (!d.code_data)                      flt = FLT_GP;
                else if (d.exec || !d.rw)              flt = FLT_GP;
                else if ((rpl != cpl) || (rpl != d.dpl)) flt = FLT_GP;
                else if (!d.present)                   flt = FLT_SS;
            end
            SC_CODE: begin
                if (!d.code_data)                      flt = FLT_GP;
                else if (!d.present)                   flt = FLT_NP;
                else if (!d.exec)                      flt = FLT_GP;
                else if (d.conf) begin
                    if (d.dpl > cpl)                   flt = FLT_GP;
                end else begin
                    if ((rpl > cpl) || (cpl != d.dpl)) flt = FLT_GP;
                end
            end
            default: begin
                if (!d.code_data)                      flt = FLT_GP;
                else if ((rpl > d.dpl) || (cpl > d.dpl)) flt = FLT_GP;
                else if (!d.present)                   flt = FLT_NP;
            end
        endcase
        err = (flt == FLT_NONE) ? '0 : sel;
    end
endmodule

// File: rtl/seg_cache.sv
module seg_cache
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_real,
    input  logic [SEL_W-1:0]  real_sel,
    input  logic              upd_prot,
    input  cache_t            prot_val,
    output cache_t            cache
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cache.sel   <= '0;
            cache.base  <= '0;
            cache.limit <= RESET_LIMIT;
            cache.attr  <= '0;
        end else if (upd_prot) begin
            cache <= prot_val;
        end else if (upd_real) begin
            cache.sel  <= real_sel;
            cache.base <= ADDR_W'(real_sel) << REAL_SH;
        end
    end

    AST_REAL_KEEPS_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (upd_real && !upd_prot) |=> ($stable(cache.limit) && $stable(cache.attr))); // R2
endmodule

// File: rtl/seg_loader.sv
module seg_loader
    import seg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [15:0]       req_sel,
    input  logic [1:0]        req_class,
    input  logic              pe,
    input  logic              v86,
    input  logic [1:0]        cpl_in,
    input  logic [31:0]       gdt_base,
    input  logic [15:0]       gdt_limit,
    input  logic [31:0]       ldt_base,
    input  logic [15:0]       ldt_limit,
    output logic              mem_req,
    output logic [31:0]       mem_addr,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        flt_code,
    output logic [15:0]       flt_err,
    output logic              cpl_wr,
    output logic [1:0]        cpl_new,
    output logic [15:0]       cur_sel,
    output logic [31:0]       cur_base,
    output logic [31:0]       cur_limit,
    output logic [8:0]        cur_attr
);
    typedef enum logic {ST_IDLE = 1'b0, ST_READ = 1'b1} st_e;

    st_e               st;
    logic [SEL_W-1:0]  cap_sel;
    seg_class_e        cap_cls;
    logic [PL_W-1:0]   cap_cpl;
    logic [ADDR_W-1:0] addr_q;
    logic              done_q;
    fault_e            flt_q;
    logic [SEL_W-1:0]  err_q;
    logic              cplwr_q;
    logic [PL_W-1:0]   cplnew_q;

    seg_class_e        in_cls;
    logic              take;
    logic              prot_mode;
    logic [ADDR_W-1:0] pre_addr;
    fault_e            pre_flt;
    logic [SEL_W-1:0]  pre_err;
    fault_e            chk_flt;
    logic [SEL_W-1:0]  chk_err;
    logic              desc_in;
    logic              upd_real;
    logic              upd_prot;
    cache_t            prot_val;
    cache_t            cache;
    desc_t             rd_desc;

    assign in_cls    = seg_class_e'(req_class);
    assign take      = req_valid && (st == ST_IDLE);
    assign prot_mode = pe && !v86;
    assign desc_in   = (st == ST_READ) && mem_ack;
    assign upd_real  = take && !prot_mode;
    assign upd_prot  = desc_in && (chk_flt == FLT_NONE);
    assign rd_desc   = desc_t'(mem_rdata);

    always_comb begin
        prot_val.sel   = cap_sel;
        prot_val.base  = desc_base(rd_desc);
        prot_val.limit = desc_limit(rd_desc);
        prot_val.attr  = desc_attr(rd_desc);
    end

    seg_precheck u_pre (
        .sel       (req_sel),
        .cls       (in_cls),
        .gdt_base  (gdt_base),
        .gdt_limit (gdt_limit),
        .ldt_base  (ldt_base),
        .ldt_limit (ldt_limit),
        .rd_addr   (pre_addr),
        .pre_flt   (pre_flt),
        .pre_err   (pre_err)
    );

    seg_desc_check u_chk (
        .cls      (cap_cls),
        .sel      (cap_sel),
        .cpl      (cap_cpl),
        .desc_raw (mem_rdata),
        .flt      (chk_flt),
        .err      (chk_err)
    );

    seg_cache u_cache (
        .clk      (clk),
        .rst      (rst),
        .upd_real (upd_real),
        .real_sel (req_sel),
        .upd_prot (upd_prot),
        .prot_val (prot_val),
        .cache    (cache)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cap_sel  <= '0;
            cap_cls  <= SC_DATA;
            cap_cpl  <= '0;
            addr_q   <= '0;
            done_q   <= 1'b0;
            flt_q    <= FLT_NONE;
            err_q    <= '0;
            cplwr_q  <= 1'b0;
            cplnew_q <= '0;
        end else begin
            done_q  <= 1'b0;
            cplwr_q <= 1'b0;
            if (take) begin
                cap_sel <= req_sel;
                cap_cls <= in_cls;
                cap_cpl <= eff_priv(v86, cpl_in);
                if (!prot_mode) begin
                    done_q <= 1'b1;
                    flt_q  <= FLT_NONE;
                    err_q  <= '0;
                end else if (pre_flt != FLT_NONE) begin
                    done_q <= 1'b1;
                    flt_q  <= pre_flt;
                    err_q  <= pre_err;
                end else begin
                    st     <= ST_READ;
                    addr_q <= pre_addr;
                end
            end else if (desc_in) begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
                flt_q  <= chk_flt;
                err_q  <= chk_err;
                if ((chk_flt == FLT_NONE) && (cap_cls == SC_CODE)) begin
                    cplwr_q  <= 1'b1;
                    cplnew_q <= cap_sel[PL_W-1:0];
                end
            end
        end
    end

    assign mem_req   = (st == ST_READ);
    assign mem_addr  = addr_q;
    assign busy      = (st == ST_READ);
    assign done      = done_q;
    assign flt_code  = flt_q;
    assign flt_err   = err_q;
    assign cpl_wr    = cplwr_q;
    assign cpl_new   = cplnew_q;
    assign cur_sel   = cache.sel;
    assign cur_base  = cache.base;
    assign cur_limit = cache.limit;
    assign cur_attr  = cache.attr;

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10

    AST_CPL_ONLY_ON_OK: assert property (@(posedge clk) disable iff (rst)
        cpl_wr |-> (done && flt_code == FLT_NONE)); // R8

    AST_FAULT_HOLDS_CACHE: assert property (@(posedge clk) disable iff (rst)
        (done && flt_code != FLT_NONE) |-> (cur_sel == $past(cur_sel) && cur_base == $past(cur_base)
                                            && cur_limit == $past(cur_limit))); // R9

    AST_SS_ONLY_STACK: assert property (@(posedge clk) disable iff (rst)
        (done && flt_code == FLT_SS) |-> (cap_cls == SC_STACK)); // R4

    AST_NO_READ_REAL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy && !(pe && !v86)) |=> !mem_req); // R2
endmodule

// File: tb/seg_loader_tb.sv
module seg_loader_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [15:0] req_sel;
    logic [1:0]  req_class;
    logic        pe, v86;
    logic [1:0]  cpl_in;
    logic [31:0] gdt_base, ldt_base;
    logic [15:0] gdt_limit, ldt_limit;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack;
    logic [63:0] mem_rdata;
    logic        busy, done, cpl_wr;
    logic [1:0]  flt_code, cpl_new;
    logic [15:0] flt_err, cur_sel;
    logic [31:0] cur_base, cur_limit;
    logic [8:0]  cur_attr;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    seg_loader u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_sel(req_sel), .req_class(req_class),
        .pe(pe), .v86(v86), .cpl_in(cpl_in), .gdt_base(gdt_base), .gdt_limit(gdt_limit),
        .ldt_base(ldt_base), .ldt_limit(ldt_limit), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done), .flt_code(flt_code),
        .flt_err(flt_err), .cpl_wr(cpl_wr), .cpl_new(cpl_new), .cur_sel(cur_sel),
        .cur_base(cur_base), .cur_limit(cur_limit), .cur_attr(cur_attr)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic [1:0]  cls;
        logic [15:0] sel;
        logic [1:0]  cpl;
        logic        pe;
        logic        v86;
        logic [31:0] dbase;
        logic [19:0] dlim;
        logic [7:0]  acc;
        logic        g;
        logic        d;
        logic [1:0]  eflt;
        logic [15:0] eerr;
        logic        erd;
    } vec_t;

    localparam int NV = 32;
    // rq field names the requirement: 2=R2 3=R3 4=R4 5=R5 6=R6 7=R7 8=R8
    localparam vec_t VECS [NV] = '{
        '{4'd2, 2'd0, 16'h1234, 2'd0, 1'b0, 1'b0, 32'h0, 20'h0, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0},
        '{4'd2, 2'd0, 16'hB800, 2'd0, 1'b1, 1'b1, 32'h0, 20'h0, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0},
        '{4'd7, 2'd0, 16'h0010, 2'd0, 1'b1, 1'b0, 32'h0040_0000, 20'hFFFFF, 8'h92, 1'b1, 1'b1, 2'd0, 16'h0, 1'b1},
        '{4'd8, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0FFFF, 8'h9A, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1},
        '{4'd7, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h1234_1000, 20'h00FFF, 8'h92, 1'b0, 1'b1, 2'd0, 16'h0, 1'b1},
        '{4'd3, 2'd0, 16'h000F, 2'd3, 1'b1, 1'b0, 32'h0000_8000, 20'h000FF, 8'hF2, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1},
        '{4'd3, 2'd0, 16'h0100, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h92, 1'b0, 1'b0, 2'd1, 16'h0100, 1'b0},
        '{4'd3, 2'd0, 16'h0024, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h92, 1'b0, 1'b0, 2'd1, 16'h0024, 1'b0},
        '{4'd3, 2'd0, 16'h00F8, 2'd0, 1'b1, 1'b0, 32'h00AB_CD00, 20'h00010, 8'h92, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1},
        '{4'd4, 2'd2, 16'h0003, 2'd3, 1'b1, 1'b0, 32'h0, 20'h0, 8'h92, 1'b0, 1'b0, 2'd1, 16'h0000, 1'b0},
        '{4'd5, 2'd1, 16'h0000, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h9A, 1'b0, 1'b0, 2'd1, 16'h0000, 1'b0},
        '{4'd6, 2'd0, 16'h0000, 2'd0, 1'b1, 1'b0, 32'h0000_0500, 20'h00400, 8'h92, 1'b0, 1'b0, 2'd0, 16'h0, 1'b1},
        '{4'd4, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h82, 1'b0, 1'b0, 2'd1, 16'h0018, 1'b1},
        '{4'd4, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h9A, 1'b0, 1'b0, 2'd1, 16'h0018, 1'b1},
        '{4'd4, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h90, 1'b0, 1'b0, 2'd1, 16'h0018, 1'b1},
        '{4'd4, 2'd2, 16'h001B, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'hF2, 1'b0, 1'b0, 2'd1, 16'h001B, 1'b1},
        '{4'd4, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'hF2, 1'b0, 1'b0, 2'd1, 16'h0018, 1'b1},
        '{4'd4, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h12, 1'b0, 1'b0, 2'd3, 16'h0018, 1'b1},
        '{4'd4, 2'd2, 16'h0018, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h10, 1'b0, 1'b0, 2'd1, 16'h0018, 1'b1},
        '{4'd5, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h1A, 1'b0, 1'b0, 2'd2, 16'h0008, 1'b1},
        '{4'd5, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h12, 1'b0, 1'b0, 2'd2, 16'h0008, 1'b1},
        '{4'd5, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h92, 1'b0, 1'b0, 2'd1, 16'h0008, 1'b1},
        '{4'd5, 2'd1, 16'h000B, 2'd3, 1'b1, 1'b0, 32'h0002_0000, 20'h0FFFF, 8'h9E, 1'b0, 1'b1, 2'd0, 16'h0, 1'b1},
        '{4'd5, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'hFE, 1'b0, 1'b0, 2'd1, 16'h0008, 1'b1},
        '{4'd5, 2'd1, 16'h000B, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h9A, 1'b0, 1'b0, 2'd1, 16'h000B, 1'b1},
        '{4'd5, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'hFA, 1'b0, 1'b0, 2'd1, 16'h0008, 1'b1},
        '{4'd5, 2'd1, 16'h0008, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h8A, 1'b0, 1'b0, 2'd1, 16'h0008, 1'b1},
        '{4'd6, 2'd0, 16'h0010, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h02, 1'b0, 1'b0, 2'd1, 16'h0010, 1'b1},
        '{4'd6, 2'd0, 16'h0013, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h92, 1'b0, 1'b0, 2'd1, 16'h0013, 1'b1},
        '{4'd6, 2'd3, 16'h0010, 2'd3, 1'b1, 1'b0, 32'h0, 20'h0, 8'h92, 1'b0, 1'b0, 2'd1, 16'h0010, 1'b1},
        '{4'd6, 2'd0, 16'h0010, 2'd0, 1'b1, 1'b0, 32'h0, 20'h0, 8'h12, 1'b0, 1'b0, 2'd2, 16'h0010, 1'b1},
        '{4'd2, 2'd0, 16'hFFFF, 2'd0, 1'b0, 1'b0, 32'h0, 20'h0, 8'h00, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0}
    };

    logic [15:0] m_sel;
    logic [31:0] m_base, m_limit;
    logic [8:0]  m_attr;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mkdesc(input vec_t v);
        return {v.dbase[31:24], v.g, v.d, 2'b00, v.dlim[19:16], v.acc, v.dbase[23:0], v.dlim[15:0]};
    endfunction

    task automatic check_cache(input string tag);
        chk(cur_sel == m_sel, {tag, " sel"}, 64'(cur_sel), 64'(m_sel));
        chk(cur_base == m_base, {tag, " base"}, 64'(cur_base), 64'(m_base));
        chk(cur_limit == m_limit, {tag, " limit"}, 64'(cur_limit), 64'(m_limit));
        chk(cur_attr == m_attr, {tag, " attr"}, 64'(cur_attr), 64'(m_attr));
    endtask

    task automatic run_vec(input vec_t v, input int idx);
        string tag;
        bit saw_rd, saw_done, saw_cplwr;
        logic [31:0] rd_addr, exp_addr;
        logic [1:0]  got_cpl;
        logic [1:0]  got_flt;
        logic [15:0] got_err;
        tag = $sformatf("R%0d vec%0d", v.rq, idx);
        saw_rd = 0; saw_done = 0; saw_cplwr = 0; rd_addr = '0; got_cpl = '0;
        got_flt = '0; got_err = '0;
        @(negedge clk);
        req_valid = 1; req_sel = v.sel; req_class = v.cls; cpl_in = v.cpl; pe = v.pe; v86 = v.v86;
        @(negedge clk);
        req_valid = 0;
        for (int w = 0; w < 20; w++) begin
            if (done) begin
                saw_done = 1; saw_cplwr = cpl_wr; got_cpl = cpl_new;
                got_flt = flt_code; got_err = flt_err;
                break;
            end
            if (mem_req) begin
                saw_rd = 1; rd_addr = mem_addr;
                mem_ack = 1; mem_rdata = mkdesc(v);
            end
            @(negedge clk);
            mem_ack = 0;
        end
        chk(saw_done, {tag, " done R10"}, 64'(saw_done), 64'd1);
        chk(saw_rd == v.erd, {tag, " read made"}, 64'(saw_rd), 64'(v.erd));
        exp_addr = (v.sel[2] ? ldt_base : gdt_base) + {16'h0, v.sel[15:3], 3'b000};
        if (v.erd)
            chk(rd_addr == exp_addr, {tag, " addr R3"}, 64'(rd_addr), 64'(exp_addr));
        chk(got_flt == v.eflt, {tag, " fault code R9"}, 64'(got_flt), 64'(v.eflt));
        if (v.eflt != 0)
            chk(got_err == v.eerr, {tag, " error code R9"}, 64'(got_err), 64'(v.eerr));
        if (v.eflt == 0) begin
            m_sel = v.sel;
            if (!v.pe || v.v86) begin
                m_base = {12'h0, v.sel, 4'h0};
            end else begin
                m_base  = v.dbase;
                m_limit = v.g ? {v.dlim, 12'h000} : {12'h000, v.dlim};
                m_attr  = {v.d, v.acc};
            end
        end
        check_cache(tag);
        begin
            bit exp_cw;
            exp_cw = (v.eflt == 0) && v.pe && !v.v86 && (v.cls == 2'd1);
            chk(saw_cplwr == exp_cw, {tag, " cpl_wr R8"}, 64'(saw_cplwr), 64'(exp_cw));
            if (exp_cw)
                chk(got_cpl == v.sel[1:0], {tag, " cpl_new R8"}, 64'(got_cpl), 64'(v.sel[1:0]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog R10 actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; req_valid = 0; req_sel = '0; req_class = '0; pe = 0; v86 = 0; cpl_in = '0;
        gdt_base = 32'h0001_0000; gdt_limit = 16'h00FF;
        ldt_base = 32'h0002_0000; ldt_limit = 16'h001F;
        mem_ack = 0; mem_rdata = '0;
        m_sel = '0; m_base = '0; m_limit = 32'h0000_FFFF; m_attr = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check_cache("R1 reset");
        chk(!busy && !done && !mem_req && !cpl_wr, "R1 reset strobes", {busy, done, mem_req, cpl_wr}, 64'd0);
        chk(flt_code == 2'd0, "R1 reset fault", 64'(flt_code), 64'd0);

        for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

        // R10: stalled acknowledge, second request while busy is ignored
        @(negedge clk);
        req_valid = 1; req_sel = 16'h0020; req_class = 2'd0; cpl_in = 2'd0; pe = 1; v86 = 0;
        @(negedge clk);
        req_sel = 16'h0028;
        chk(mem_req && busy, "R10 busy on read", {mem_req, busy}, 64'd3);
        chk(mem_addr == 32'h0001_0020, "R10 first addr", 64'(mem_addr), 64'h10020);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(mem_req && mem_addr == 32'h0001_0020, "R10 addr held", 64'(mem_addr), 64'h10020);
        mem_ack = 1;
        mem_rdata = {8'h00, 1'b0, 1'b0, 2'b00, 4'h0, 8'h92, 24'h00_7700, 16'h0100};
        @(negedge clk);
        mem_ack = 0;
        chk(done && flt_code == 2'd0, "R10 done after ack", {done, flt_code}, 64'h4);
        m_sel = 16'h0020; m_base = 32'h0000_7700; m_limit = 32'h0000_0100; m_attr = 9'h092;
        check_cache("R10 stalled load");
        @(negedge clk);
        chk(!done && !busy && !mem_req, "R10 ignored request", {done, busy, mem_req}, 64'd0);
        check_cache("R10 after ignore");

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule